// File: doc/BRIEF.md
# Checksum-Scan Bit-Flip Test Access

This block wraps an n-bit data register that is guarded by an l-bit checksum, where l = ceil(log2(n+1)). The checksum of a word is the XOR of the one-based positions of all of its set bits. The signature is the stored checksum XOR the checksum recomputed from the live register. A decoder turns a non-zero signature into a single-bit inversion of the data register.

For test, the stored checksum register doubles as a serial shift chain. The decoder is blocked while the chain shifts, and while a capture is in progress. A built-in sequencer takes a stream of target bit positions. For each position it forms the word `position XOR recomputed checksum` and shifts it into the chain, most significant bit first, in l cycles. At the same time the old checksum leaves the chain and is assembled into a compacted response word. In the next cycle the signature equals the target position, so that one bit of the data register inverts.

A target marked last closes the pattern. One cycle later the block pulses capture, which loads the data register from the functional input and reloads the checksum to match. A multi-bit change of state is therefore built from a run of single inversions. Each inversion costs l+1 cycles, and the capture adds one.

Top module: `bit_flip_scan_access`

## Requirements
- R1: After reset the data register and stored checksum are zero, tgt_ready is 1, and scan_en, resp_valid, cap_pulse and done are 0.
- R2: Bit position a (1..n) is held in reg_q[a-1]. A capture loads reg_q from cap_data and sets the stored checksum to the XOR of the positions of the set bits of cap_data.
- R3: An accepted target with position 1..n drives scan_en high for exactly l consecutive cycles, and reg_q does not change during those cycles.
- R4: In the cycle after the l shift cycles (scan_en low), exactly one bit of reg_q inverts, and it is the bit at the target position.
- R5: Each non-zero target produces one response word on resp_chk. That word equals the stored checksum as it stood before the shift: the recomputed checksum after a capture, or otherwise the word shifted in for the previous target.
- R6: A target of position 0 is accepted but skipped. It causes no shift, no response and no change to reg_q.
- R7: cap_pulse is high for one cycle. It follows the inversion cycle of a last target, or comes directly after accepting a last target of position 0. done pulses in the cycle after cap_pulse.
- R8: After done, cyc_count equals bf*(l+1)+1, where bf is the number of non-zero targets in the pattern.
- R9: Targets use valid/ready and transfer when both are high. Responses use valid/ready. While resp_valid is high and resp_ready is low, resp_valid and resp_chk hold steady. tgt_ready is low whenever a response is pending or a target is being processed.
- R10: After a run of inversions, reg_q at capture equals the start state with every listed position inverted once per occurrence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_valid | input | 1 | Target position offered |
| tgt_ready | output | 1 | Sequencer can take a target |
| tgt_addr | input | L | Target bit position, 1..n; 0 is skipped |
| tgt_last | input | 1 | Target closes the pattern |
| cap_data | input | N | Functional value loaded at capture |
| resp_valid | output | 1 | Compacted response available |
| resp_ready | input | 1 | Consumer takes the response |
| resp_chk | output | L | Compacted response (previous checksum) |
| reg_q | output | N | Data register contents |
| scan_en | output | 1 | Checksum chain is shifting |
| cap_pulse | output | 1 | Capture cycle |
| done | output | 1 | Pattern finished, one cycle after capture |
| cyc_count | output | CNT_W | Shift, flip and capture cycles of the last pattern |

## Verification
The hardest case to reach is a response held back by the consumer while further targets wait. The shift word depends on the register value at the moment a target is accepted, so a stall shifts every later checksum in time but must not change its value. The stimulus drops resp_ready in the middle of a pattern and holds it low for several cycles. During that time the bench confirms that targets are refused and that the response stays frozen. It then releases resp_ready and checks the rest of the pattern. Zero positions are placed inside patterns and alone as a last target, and one pattern inverts every bit, so the cycle total and the final register are checked at both ends of the flip count.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_FLIP  = 2'd2,
    ST_CAP   = 2'd3
  } bfs_state_e;
endpackage

// File: rtl/bfs_chk_calc.sv
module bfs_chk_calc #(
  parameter int N = 15,
  parameter int L = 4
) (
  input  logic [N-1:0] word,
  output logic [L-1:0] chk
);
  // XOR of the one-based positions of all set bits
  always_comb begin
    chk = '0;
    for (int i = 0; i < N; i++) begin
      if (word[i]) chk = chk ^ L'(i + 1);
    end
  end
endmodule

// File: rtl/bfs_decoder.sv
module bfs_decoder #(
  parameter int N = 15,
  parameter int L = 4
) (
  input  logic         en,
  input  logic [L-1:0] sig,
  output logic [N-1:0] flip_vec
);
  for (genvar g = 0; g < N; g++) begin : g_dec
    assign flip_vec[g] = en && (sig == L'(g + 1));
  end
endmodule

// File: rtl/bfs_sequencer.sv
module bfs_sequencer
  import bfs_pkg::*;
#(
  parameter int N     = 15,
  parameter int L     = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgt_valid,
  output logic             tgt_ready,
  input  logic [L-1:0]     tgt_addr,
  input  logic             tgt_last,
  input  logic [L-1:0]     recomp,
  input  logic             scan_out,
  output logic             scan_en,
  output logic             scan_bit,
  output logic             cap_pulse,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [L-1:0]     resp_chk,
  output logic             done,
  output logic [CNT_W-1:0] cyc_count
);
  localparam int BW = $clog2(L + 1);

  bfs_state_e     state;
  logic [L-1:0]   sh_word;
  logic [BW-1:0]  bit_cnt;
  logic           pend_last;
  logic           in_pat;
  logic           addr_ok;
  logic           take;

  assign addr_ok   = (tgt_addr != '0) && (tgt_addr <= L'(N));
  assign tgt_ready = (state == ST_IDLE) && !resp_valid;
  assign take      = tgt_valid && tgt_ready;
  assign scan_en   = (state == ST_SHIFT);
  assign scan_bit  = sh_word[L-1];
  assign cap_pulse = (state == ST_CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sh_word    <= '0;
      bit_cnt    <= '0;
      pend_last  <= 1'b0;
      in_pat     <= 1'b0;
      resp_valid <= 1'b0;
      resp_chk   <= '0;
      done       <= 1'b0;
      cyc_count  <= '0;
    end else begin
      done <= 1'b0;
      if (resp_valid && resp_ready) resp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            pend_last <= tgt_last;
            in_pat    <= 1'b1;
            if (!in_pat) cyc_count <= '0;
            if (addr_ok) begin
              sh_word <= tgt_addr ^ recomp;
              bit_cnt <= '0;
              state   <= ST_SHIFT;
            end else if (tgt_last) begin
              state <= ST_CAP;
            end
          end
        end
        ST_SHIFT: begin
          cyc_count <= cyc_count + 1'b1;
          sh_word   <= sh_word << 1;
          resp_chk  <= {resp_chk[L-2:0], scan_out};
          if (bit_cnt == BW'(L - 1)) begin
            state      <= ST_FLIP;
            resp_valid <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_FLIP: begin
          cyc_count <= cyc_count + 1'b1;
          state     <= pend_last ? ST_CAP : ST_IDLE;
        end
        default: begin
          cyc_count <= cyc_count + 1'b1;
          in_pat    <= 1'b0;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bit_flip_scan_access.sv
module bit_flip_scan_access #(
  parameter int N       = 15,
  parameter int CNT_W   = 16,
  localparam int L      = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgt_valid,
  output logic             tgt_ready,
  input  logic [L-1:0]     tgt_addr,
  input  logic             tgt_last,
  input  logic [N-1:0]     cap_data,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [L-1:0]     resp_chk,
  output logic [N-1:0]     reg_q,
  output logic             scan_en,
  output logic             cap_pulse,
  output logic             done,
  output logic [CNT_W-1:0] cyc_count
);
  logic [N-1:0] data_q;
  logic [L-1:0] chk_q;
  logic [L-1:0] recomp;
  logic [L-1:0] cap_chk;
  logic [L-1:0] sig;
  logic [N-1:0] flip_vec;
  logic         scan_bit;

  bfs_chk_calc #(.N(N), .L(L)) u_live (.word(data_q),   .chk(recomp));
  bfs_chk_calc #(.N(N), .L(L)) u_cap  (.word(cap_data), .chk(cap_chk));

  assign sig = chk_q ^ recomp;

  bfs_decoder #(.N(N), .L(L)) u_dec (
    .en       (!scan_en && !cap_pulse),
    .sig      (sig),
    .flip_vec (flip_vec)
  );

  bfs_sequencer #(.N(N), .L(L), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tgt_valid  (tgt_valid),
    .tgt_ready  (tgt_ready),
    .tgt_addr   (tgt_addr),
    .tgt_last   (tgt_last),
    .recomp     (recomp),
    .scan_out   (chk_q[L-1]),
    .scan_en    (scan_en),
    .scan_bit   (scan_bit),
    .cap_pulse  (cap_pulse),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_chk   (resp_chk),
    .done       (done),
    .cyc_count  (cyc_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      chk_q  <= '0;
    end else if (cap_pulse) begin
      data_q <= cap_data;
      chk_q  <= cap_chk;
    end else begin
      data_q <= data_q ^ flip_vec;
      if (scan_en) chk_q <= {chk_q[L-2:0], scan_bit};
    end
  end

  assign reg_q = data_q;
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
  parameter int N = 15,
  parameter int L = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scan_en,
  input logic [N-1:0] reg_q,
  input logic         resp_valid,
  input logic         resp_ready,
  input logic [L-1:0] resp_chk,
  input logic         tgt_ready,
  input logic         cap_pulse,
  input logic         done
);
  logic [7:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (scan_en) run <= run + 1'b1;
    else run <= '0;
  end

  assert_scan_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> (run < 8'(L)));

  assert_scan_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |-> (run == 8'(L)));

  assert_reg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (reg_q == $past(reg_q)));

  assert_flip_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |=> ($countones(reg_q ^ $past(reg_q)) == 1));

  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_chk)));

  assert_ready_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid || scan_en) |-> !tgt_ready);

  assert_done_after_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> (done && !cap_pulse));
endmodule

bind bit_flip_scan_access bfs_checker #(.N(N), .L(L)) u_bfs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_en    (scan_en),
  .reg_q      (reg_q),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_chk   (resp_chk),
  .tgt_ready  (tgt_ready),
  .cap_pulse  (cap_pulse),
  .done       (done)
);

// File: tb/bit_flip_scan_access_tb.sv
module bit_flip_scan_access_tb;
  localparam int N = 15;
  localparam int L = 4;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tgt_valid = 1'b0;
  logic             tgt_ready;
  logic [L-1:0]     tgt_addr = '0;
  logic             tgt_last = 1'b0;
  logic [N-1:0]     cap_data = '0;
  logic             resp_valid;
  logic             resp_ready = 1'b1;
  logic [L-1:0]     resp_chk;
  logic [N-1:0]     reg_q;
  logic             scan_en;
  logic             cap_pulse;
  logic             done;
  logic [CNT_W-1:0] cyc_count;

  bit_flip_scan_access #(.N(N), .CNT_W(CNT_W)) u_dut (.*);

  always #5 clk = ~clk;

  int total = 0;
  int fails = 0;
  logic [N-1:0] m_data = '0;
  logic [L-1:0] m_chk = '0;
  int bf = 0;
  logic [L-1:0] exp_q[$];

  function automatic logic [L-1:0] csum(input logic [N-1:0] w);
    logic [L-1:0] c = '0;
    for (int i = 0; i < N; i++) if (w[i]) c = c ^ L'(i + 1);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: updates the model and pushes the expected response
  task automatic send(input int a, input bit last);
    if (a != 0) begin
      exp_q.push_back(m_chk);
      m_chk = L'(a) ^ csum(m_data);
      m_data[a-1] = ~m_data[a-1];
      bf++;
    end
    @(posedge clk); #2;
    tgt_valid = 1'b1; tgt_addr = L'(a); tgt_last = last;
    forever begin
      @(negedge clk);
      if (tgt_ready) break;
    end
    @(posedge clk); #2;
    tgt_valid = 1'b0;
  endtask

  task automatic wait_done();
    forever begin
      @(negedge clk);
      if (done) break;
    end
    check(reg_q == cap_data, "R2 capture load", int'(reg_q), int'(cap_data));
    check(int'(cyc_count) == bf * (L + 1) + 1, "R8 cycle total", int'(cyc_count), bf * (L + 1) + 1);
    check(exp_q.size() == 0, "R5 all responses seen", exp_q.size(), 0);
    m_data = cap_data;
    m_chk = csum(cap_data);
    bf = 0;
  endtask

  // monitor: responses, shift run length, flip, capture
  int scan_run = 0;
  logic [N-1:0] scan_ref;
  bit scan_stable;
  bit flip_pend = 1'b0;
  logic [N-1:0] flip_ref;

  always @(negedge clk) begin
    if (rst_n) begin
      if (resp_valid && resp_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected response", int'(resp_chk), 0);
        else begin
          automatic logic [L-1:0] e = exp_q.pop_front();
          check(resp_chk == e, "R5 response", int'(resp_chk), int'(e));
        end
      end
      if (flip_pend) begin
        check($countones(reg_q ^ flip_ref) == 1, "R4 single flip", $countones(reg_q ^ flip_ref), 1);
        flip_pend = 1'b0;
      end
      if (scan_en) begin
        if (scan_run == 0) begin scan_ref = reg_q; scan_stable = 1'b1; end
        else if (reg_q != scan_ref) scan_stable = 1'b0;
        scan_run++;
      end else if (scan_run != 0) begin
        check(scan_run == L, "R3 shift length", scan_run, L);
        check(scan_stable && reg_q == scan_ref, "R3 reg hold", int'(reg_q), int'(scan_ref));
        scan_run = 0;
        flip_pend = 1'b1;
        flip_ref = reg_q;
      end
      if (cap_pulse) check(reg_q == m_data, "R10 state before capture", int'(reg_q), int'(m_data));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(reg_q == '0 && tgt_ready && !scan_en && !resp_valid && !done && !cap_pulse,
          "R1 reset state", int'(reg_q), 0);
    rst_n = 1'b1;

    // pattern 1: three flips from reset
    cap_data = 15'h2A5A;
    send(5, 0); send(9, 0); send(15, 1);
    wait_done();

    // pattern 2: zero inside, repeated bit
    cap_data = 15'h0F0F;
    send(3, 0);
    send(0, 0);
    repeat (3) begin
      @(negedge clk);
      check(!scan_en && !resp_valid && reg_q == m_data, "R6 zero target skipped", int'(reg_q), int'(m_data));
    end
    send(7, 0); send(3, 1);
    wait_done();

    // pattern 3: lone zero last target -> capture only
    cap_data = 15'h7001;
    send(0, 1);
    wait_done();

    // pattern 4: back-pressure on the response
    cap_data = 15'h1234;
    resp_ready = 1'b0;
    send(1, 0);
    forever begin @(negedge clk); if (resp_valid) break; end
    begin
      automatic logic [L-1:0] held = resp_chk;
      repeat (5) begin
        @(negedge clk);
        check(resp_valid && !tgt_ready && resp_chk == held, "R9 stall holds", int'(resp_chk), int'(held));
      end
    end
    @(posedge clk); #2; resp_ready = 1'b1;
    send(14, 1);
    wait_done();

    // pattern 5: every bit inverted
    cap_data = 15'h5555;
    for (int a = 1; a <= N; a++) send(a, a == N);
    wait_done();

    repeat (3) @(negedge clk);
    check(!done && !cap_pulse && tgt_ready, "R7 single pulses", int'(done), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule